// File: doc/BRIEF.md
# Open-Drain Line Micro-Step Engine

This block is the bottom layer of a layered two-wire serial controller. Each command it takes describes one line-level micro-step. The step says whether SDA is pulled low or let go, whether SCL is pulled low or let go, and whether the SDA level is to be captured. The engine applies the line state right away. It then holds that state until the next pulse of a shared timing tick, at which point the step ends. It flags completion with a one-cycle `done` and returns the captured bit.

The engine never drives a line high. Each line has one output enable: when it is 1 the pad pulls the line low, and when it is 0 the pad lets go and an external pull-up sets the level. The engine knows nothing of bits, bytes or bus conditions. A caller builds those by sending a sequence of micro-steps. The SDA pad input passes through a parameterised synchronizer before it is captured.

The control is a three-state machine:
- ST_IDLE waits for a command. A valid command moves it to ST_HOLD.
- ST_HOLD keeps the line state. A tick moves it to ST_DONE, and the SDA capture happens on that same edge.
- ST_DONE raises `done` for one cycle and always returns to ST_IDLE.

Top module: `ustep_engine`

## Requirements
- R1: After reset, `sda_oe` and `scl_oe` are 0 (both lines released), `cmd_ready` is 1, `done` is 0 and `rd_bit` is 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `sda_oe` equals the inverse of `cmd_sda_rel` and `scl_oe` equals the inverse of `cmd_scl_rel`, the two set independently. Enable value 1 means the line is pulled low. All four combinations are reachable.
- R3: `cmd_ready` is 1 only in ST_IDLE. A `cmd_valid` raised while a step is in progress is ignored: it changes neither line enable nor the step in progress.
- R4: A step ends at the first clock edge after acceptance where `tick` is 1, and `done` is 1 in the following cycle. A tick that is high in ST_IDLE, including on the edge that accepts a command, has no effect.
- R5: `done` lasts exactly one cycle, and `cmd_ready` is 1 again in the cycle after `done`.
- R6: If the command had `cmd_sample` = 1, then `rd_bit` holds the synchronized SDA level seen on the edge that ends the step. It is valid while `done` is 1.
- R7: If the command had `cmd_sample` = 0, then `rd_bit` keeps the value it had before the step.
- R8: The line enables keep the last applied command's values after `done`, until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Shared timing strobe that ends a step |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_sda_rel | input | 1 | 1 = release SDA, 0 = pull SDA low |
| cmd_scl_rel | input | 1 | 1 = release SCL, 0 = pull SCL low |
| cmd_sample | input | 1 | 1 = capture SDA when the step ends |
| done | output | 1 | One-cycle step completion pulse |
| rd_bit | output | 1 | Captured SDA level |
| sda_in | input | 1 | SDA pad level |
| sda_oe | output | 1 | 1 = pull SDA low |
| scl_oe | output | 1 | 1 = pull SCL low |

## Verification
A state machine stuck in ST_HOLD shows up at the first tick after a command, because `done` then fails to rise one cycle later. A machine that drops back to idle too early shows up as `cmd_ready` rising before the tick, or as a busy-time command that changes the line enables. A wrong capture path shows up as a wrong `rd_bit` in the `done` cycle itself. A sample taken when it should not be shows up as a flipped `rd_bit` after a step with sampling off. A stale or swapped enable register shows up one cycle after acceptance, because both enables are compared against the command in that cycle.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } ustep_state_e;

    typedef struct packed {
        logic sda_rel;
        logic scl_rel;
        logic sample;
    } ustep_cmd_t;

endpackage

// File: rtl/ustep_sync.sv
module ustep_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
                end else begin
                    stage_q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign d_out = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ustep_fsm.sv
module ustep_fsm
    import ustep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_valid,
    output logic accept,
    output logic finish,
    output logic cmd_ready,
    output logic done
);

    ustep_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_HOLD;
            ST_HOLD: if (tick)      state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        done      = 1'b0;
        accept    = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                accept    = cmd_valid;
            end
            ST_HOLD: finish = tick;
            ST_DONE: done   = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ustep_lines.sv
module ustep_lines
    import ustep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  ustep_cmd_t cmd,
    output logic       sda_oe,
    output logic       scl_oe
);

    // Enable = 1 pulls the line low. Lines are never driven high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else if (load) begin
            sda_oe <= ~cmd.sda_rel;
            scl_oe <= ~cmd.scl_rel;
        end
    end

endmodule

// File: rtl/ustep_engine.sv
module ustep_engine
    import ustep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_valid,
    output logic cmd_ready,
    input  logic cmd_sda_rel,
    input  logic cmd_scl_rel,
    input  logic cmd_sample,
    output logic done,
    output logic rd_bit,
    input  logic sda_in,
    output logic sda_oe,
    output logic scl_oe
);

    logic       accept;
    logic       finish;
    logic       sda_sync;
    logic       sample_q;
    ustep_cmd_t cmd_in;

    assign cmd_in = '{sda_rel: cmd_sda_rel, scl_rel: cmd_scl_rel, sample: cmd_sample};

    ustep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .accept    (accept),
        .finish    (finish),
        .cmd_ready (cmd_ready),
        .done      (done)
    );

    ustep_lines u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .cmd    (cmd_in),
        .sda_oe (sda_oe),
        .scl_oe (scl_oe)
    );

    ustep_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sda_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (sda_in),
        .d_out (sda_sync)
    );

    // Capture request latched at acceptance, SDA captured on the ending edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            if (accept)              sample_q <= cmd_in.sample;
            if (finish && sample_q)  rd_bit   <= sda_sync;
        end
    end

endmodule

// File: rtl/ustep_engine_chk.sv
module ustep_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_sda_rel,
    input logic cmd_scl_rel,
    input logic done,
    input logic rd_bit,
    input logic sda_oe,
    input logic scl_oe
);

    AST_ACCEPT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (sda_oe == !$past(cmd_sda_rel)) && (scl_oe == !$past(cmd_scl_rel))); // R2

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(sda_oe) && $stable(scl_oe)); // R3

    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tick) && !$past(cmd_ready)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready); // R5

    AST_NOT_READY_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready); // R3

    AST_RD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> done); // R7

endmodule

bind ustep_engine ustep_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_sda_rel (cmd_sda_rel),
    .cmd_scl_rel (cmd_scl_rel),
    .done        (done),
    .rd_bit      (rd_bit),
    .sda_oe      (sda_oe),
    .scl_oe      (scl_oe)
);

// File: tb/ustep_engine_tb_top.sv
`timescale 1ns/1ps
module ustep_engine_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_sda_rel = 1'b1;
    logic cmd_scl_rel = 1'b1;
    logic cmd_sample = 1'b0;
    logic sda_in = 1'b1;
    logic cmd_ready, done, rd_bit, sda_oe, scl_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    ustep_engine dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_sda_rel (cmd_sda_rel),
        .cmd_scl_rel (cmd_scl_rel),
        .cmd_sample  (cmd_sample),
        .done        (done),
        .rd_bit      (rd_bit),
        .sda_in      (sda_in),
        .sda_oe      (sda_oe),
        .scl_oe      (scl_oe)
    );

    // [6] sda_rel [5] scl_rel [4] sample [3] sda level
    // [2] exp sda_oe [1] exp scl_oe [0] exp rd_bit
    localparam int NVEC = 8;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1111_001,
        7'b0110_100,
        7'b0001_110,
        7'b1011_011,
        7'b0000_111,
        7'b1110_000,
        7'b1010_010,
        7'b0101_100
    };

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // Offer a command at a negedge; it is accepted on the following posedge
    task automatic issue(input logic sr, input logic cr, input logic smp);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_sda_rel = sr; cmd_scl_rel = cr; cmd_sample = smp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sda_oe, 1'b0, "R1 sda_oe");
        check(scl_oe, 1'b0, "R1 scl_oe");
        check(cmd_ready, 1'b1, "R1 cmd_ready");
        check(done, 1'b0, "R1 done");
        check(rd_bit, 1'b0, "R1 rd_bit");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            sda_in = VEC[v][3];
            repeat (3) @(negedge clk);
            issue(VEC[v][6], VEC[v][5], VEC[v][4]);
            check(sda_oe, VEC[v][2], "R2 sda_oe");
            check(scl_oe, VEC[v][1], "R2 scl_oe");
            check(cmd_ready, 1'b0, "R3 busy");
            repeat (2) @(negedge clk);
            check(done, 1'b0, "R4 no done before tick");
            pulse_tick();
            check(done, 1'b1, "R4 done after tick");
            check(rd_bit, VEC[v][0], VEC[v][4] ? "R6 rd_bit" : "R7 rd_bit");
            @(negedge clk);
            check(done, 1'b0, "R5 done one cycle");
            check(cmd_ready, 1'b1, "R5 ready again");
            repeat (3) @(negedge clk);
            check(sda_oe, VEC[v][2], "R8 sda_oe held");
            check(scl_oe, VEC[v][1], "R8 scl_oe held");
        end

        // R4: tick while idle does nothing
        pulse_tick();
        check(done, 1'b0, "R4 idle tick");
        @(negedge clk);
        check(done, 1'b0, "R4 idle tick later");

        // R4: tick on the accepting edge is ignored; R3: busy command ignored
        sda_in = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_sda_rel = 1'b0; cmd_scl_rel = 1'b0; cmd_sample = 1'b1; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; cmd_sda_rel = 1'b1; cmd_scl_rel = 1'b1; cmd_sample = 1'b0;
        check(sda_oe, 1'b1, "R2 sda_oe low");
        check(scl_oe, 1'b1, "R2 scl_oe low");
        repeat (2) @(negedge clk);
        check(done, 1'b0, "R4 accept-edge tick ignored");
        check(sda_oe, 1'b1, "R3 busy cmd ignored sda");
        check(scl_oe, 1'b1, "R3 busy cmd ignored scl");
        cmd_valid = 1'b0;
        pulse_tick();
        check(done, 1'b1, "R4 done");
        check(rd_bit, 1'b1, "R6 rd_bit sampled high");
        @(negedge clk);
        check(cmd_ready, 1'b1, "R5 ready");
        check(sda_oe, 1'b1, "R8 sda_oe kept");

        finish_run();
    end

endmodule